// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block is a read-only bus slave that serves CPU loads from a window mapped onto a serial NOR flash. Each load in the window becomes one complete flash read on the serial bus. The block asserts chip select, sends the command byte, sends the window offset as the flash address, clocks any dummy cycles and then gathers one bus word of read data. The requester is held in a wait state until the word is assembled. The flash address is the offset itself. No base is added and no translation is done.

The read format comes from shared transfer settings rather than being fixed. These settings cover whether a command byte is sent, the opcode, 3- or 4-byte addressing, a 4-byte-command flag, fast mode, dummy clock count and data lane width. The command and address always travel on lane 0 only, which gives the 1-1-1, 1-1-2 and 1-1-4 formats. A one-bit map-enable register comes up enabled after reset. The engine owns chip select only while the chip-enable control is in hardware mode (value 0). While the map is enabled, the start strobe of the separate register-mode transfer path is blocked.

Top module: `flash_window_reader`

## Requirements
- R1: The map-enable register is 1 after reset. A write sets it to the written bit, and the new value applies from the next cycle.
- R2: A load while the map is disabled, or while `ce_mode` is not 0, completes with `bus_ready` on the first edge after the request. It returns all-zero data, and `spi_sck` does not toggle.
- R3: An active load drives `spi_csn` low on the accepting edge and keeps it low until the completion edge. When `cfg_with_cmd` is 1, the first 8 serial clocks carry `cfg_opcode` MSB first on `spi_io_out[0]`.
- R4: The address phase sends the low bytes of `bus_addr`, MSB first on `spi_io_out[0]`. It uses 4 bytes when `cfg_addr4` or `cfg_cmd4` is 1, and 3 bytes otherwise.
- R5: When `cfg_with_cmd` is 0, no command byte is sent and the address phase starts on the first serial clock.
- R6: After the address, `cfg_dummy` (0 to 15) serial clocks are inserted when `cfg_fast` is 1. No dummy clocks are inserted when `cfg_fast` is 0.
- R7: The data phase samples on each rising `spi_sck` edge, MSB first per byte. `cfg_lanes` selects the lanes: 0 = one lane on `spi_io_in[1]`; 1 = two lanes `spi_io_in[1:0]` with bit 1 first; 2 = four lanes `spi_io_in[3:0]` with bit 3 first; 3 = one lane as for 0. The first flash byte goes to `bus_rdata[7:0]`, with later bytes in rising byte lanes.
- R8: `spi_sck` idles low and runs at half the clock rate, each serial clock taking two cycles. With N serial clocks in the frame, `bus_ready` pulses for one cycle after 2N+1 rising clock edges, counting the accepting edge.
- R9: `spi_csn` returns high on the completion edge, and it is high with `spi_sck` low while no load is active. In manual chip-enable mode (`ce_mode` not 0), `spi_csn` follows `ce_mode[0]`.
- R10: `spi_io_oe` is 4'b0001 through the command and address phases and 4'b0000 through the dummy and data phases.
- R11: `reg_start` stays low for `reg_go` while the map is enabled, and follows `reg_go` while the map is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr | input | 1 | Write strobe for the map-enable register |
| map_wdata | input | 1 | Value written to the map-enable register |
| ce_mode | input | 2 | Chip-enable control: 0 hardware, else manual with bit 0 as the pin level |
| cfg_with_cmd | input | 1 | Send a command byte before the address |
| cfg_addr4 | input | 1 | Use 4 address bytes |
| cfg_cmd4 | input | 1 | 4-byte command flag, forces 4 address bytes |
| cfg_fast | input | 1 | Enable dummy clocks |
| cfg_lanes | input | 2 | Data lane width code |
| cfg_dummy | input | 4 | Dummy clock count |
| cfg_opcode | input | 8 | Command byte |
| reg_go | input | 1 | Start request for the register-mode path |
| reg_start | output | 1 | Start request passed on to the register-mode path |
| bus_req | input | 1 | Load request, held until `bus_ready` |
| bus_addr | input | ADDR_W | Window offset of the load |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8*BUS_BYTES | Load data, valid with `bus_ready` |
| spi_sck | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Serial data out |
| spi_io_oe | output | 4 | Output enables for the serial data lines |
| spi_io_in | input | 4 | Serial data in |

## Verification
The in-RTL assertions check the following on every cycle: chip select stays high whenever the sequencer is idle, the serial clock rises only inside a frame, the completion pulse lasts one cycle, the data lines are released whenever read data is sampled, a rejected load completes on the next edge with zero data, and a map-enable write takes effect on the next cycle. The bench scenarios are needed for the rest. Its flash model shows the bit order of command and address, the address length chosen by the two flags, the dummy count with fast mode off and on, the lane mapping and byte order of returned data, and the exact latency for each format. They also cover blocking of the register-mode start and the manual chip-enable levels.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA
  } seq_state_e;

  // Format latched at the start of each load
  typedef struct packed {
    logic [2:0] addr_bytes;
    logic [3:0] dummy;
    logic [1:0] lane_code;
  } frame_cfg_t;

endpackage

// File: rtl/fwr_map_reg.sv
module fwr_map_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic map_wr,
  input  logic map_wdata,
  input  logic reg_go,
  output logic map_en,
  output logic reg_start
);

  logic map_en_q;
  logic map_en_d;

  always_comb begin
    map_en_d = map_en_q;
    if (map_wr) map_en_d = map_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_en_q <= 1'b1;
    else        map_en_q <= map_en_d;
  end

  assign map_en    = map_en_q;
  // register-mode start is blocked while the window owns the bus
  assign reg_start = reg_go & ~map_en_q;

  // R1: a write lands on the following cycle
  a_r1_write_effect: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> (map_en == $past(map_wdata)));

endmodule

// File: rtl/fwr_rx_gather.sv
module fwr_rx_gather #(
  parameter int BUS_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   sample,
  input  logic [1:0]             lane_code,
  input  logic [3:0]             io_in,
  output logic [8*BUS_BYTES-1:0] word
);

  localparam int DW = 8 * BUS_BYTES;

  logic [DW-1:0] rx_q;
  logic [DW-1:0] rx_d;

  always_comb begin
    rx_d = rx_q;
    if (clear) begin
      rx_d = '0;
    end else if (sample) begin
      case (lane_code)
        2'd1:    rx_d = {rx_q[DW-3:0], io_in[1:0]};
        2'd2:    rx_d = {rx_q[DW-5:0], io_in[3:0]};
        default: rx_d = {rx_q[DW-2:0], io_in[1]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  // first received byte sits highest in the shifter; it maps to byte lane 0
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    assign word[8*k +: 8] = rx_q[8*(BUS_BYTES-1-k) +: 8];
  end

endmodule

// File: rtl/fwr_sequencer.sv
module fwr_sequencer
  import fwr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BUS_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   engine_ok,
  input  logic                   cfg_with_cmd,
  input  logic                   cfg_addr4,
  input  logic                   cfg_cmd4,
  input  logic                   cfg_fast,
  input  logic [1:0]             cfg_lanes,
  input  logic [3:0]             cfg_dummy,
  input  logic [7:0]             cfg_opcode,
  input  logic [8*BUS_BYTES-1:0] rx_word,
  output logic                   bus_ready,
  output logic [8*BUS_BYTES-1:0] bus_rdata,
  output logic                   sck,
  output logic                   csn_hw,
  output logic                   io_out0,
  output logic [3:0]             io_oe,
  output logic                   rx_clear,
  output logic                   rx_sample,
  output logic [1:0]             lane_code
);

  localparam int DW      = 8 * BUS_BYTES;
  localparam int CNT_MAX = (DW > 32) ? DW : 32;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int SH_W    = 40;

  seq_state_e      state_q, state_d;
  frame_cfg_t      cfg_q, cfg_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [SH_W-1:0] sh_q, sh_d;
  logic            sck_q, sck_d;
  logic            csn_q, csn_d;
  logic            ready_q, ready_d;
  logic [DW-1:0]   rdata_q, rdata_d;

  logic [2:0]      nb_new;
  logic [31:0]     addr32;
  logic [SH_W-1:0] load_v;
  logic [CW-1:0]   addr_clks;
  logic [CW-1:0]   data_clks;

  assign addr32 = 32'(bus_addr);
  assign nb_new = (cfg_addr4 | cfg_cmd4) ? 3'd4 : 3'd3;

  always_comb begin
    if (nb_new == 3'd4) load_v = {cfg_opcode, addr32};
    else                load_v = {cfg_opcode, addr32[23:0], 8'h00};
    if (!cfg_with_cmd)  load_v = {load_v[SH_W-9:0], 8'h00};
  end

  assign addr_clks = CW'({cfg_q.addr_bytes, 3'b000});

  always_comb begin
    case (cfg_q.lane_code)
      2'd1:    data_clks = CW'(DW / 2);
      2'd2:    data_clks = CW'(DW / 4);
      default: data_clks = CW'(DW);
    endcase
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cfg_d     = cfg_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    sck_d     = sck_q;
    csn_d     = csn_q;
    ready_d   = 1'b0;
    rdata_d   = rdata_q;
    rx_clear  = 1'b0;
    rx_sample = 1'b0;
    if (state_q == ST_IDLE) begin
      if (bus_req && !ready_q) begin
        if (engine_ok) begin
          csn_d           = 1'b0;
          sck_d           = 1'b0;
          sh_d            = load_v;
          rx_clear        = 1'b1;
          cfg_d.addr_bytes = nb_new;
          cfg_d.dummy     = cfg_fast ? cfg_dummy : 4'd0;
          cfg_d.lane_code = cfg_lanes;
          if (cfg_with_cmd) begin
            state_d = ST_CMD;
            cnt_d   = CW'(7);
          end else begin
            state_d = ST_ADDR;
            cnt_d   = CW'({nb_new, 3'b000}) - CW'(1);
          end
        end else begin
          ready_d = 1'b1;
          rdata_d = '0;
        end
      end
    end else if (!sck_q) begin
      sck_d     = 1'b1;
      rx_sample = (state_q == ST_DATA);
    end else begin
      sck_d = 1'b0;
      sh_d  = {sh_q[SH_W-2:0], 1'b0};
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CW'(1);
      end else begin
        case (state_q)
          ST_CMD: begin
            state_d = ST_ADDR;
            cnt_d   = addr_clks - CW'(1);
          end
          ST_ADDR: begin
            if (cfg_q.dummy != 4'd0) begin
              state_d = ST_DUMMY;
              cnt_d   = CW'(cfg_q.dummy) - CW'(1);
            end else begin
              state_d = ST_DATA;
              cnt_d   = data_clks - CW'(1);
            end
          end
          ST_DUMMY: begin
            state_d = ST_DATA;
            cnt_d   = data_clks - CW'(1);
          end
          default: begin
            state_d = ST_IDLE;
            csn_d   = 1'b1;
            ready_d = 1'b1;
            rdata_d = rx_word;
          end
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      sck_q   <= sck_d;
      csn_q   <= csn_d;
      ready_q <= ready_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;
  assign sck       = sck_q;
  assign csn_hw    = csn_q;
  assign io_out0   = sh_q[SH_W-1];
  assign io_oe     = (state_q == ST_CMD || state_q == ST_ADDR) ? 4'b0001 : 4'b0000;
  assign lane_code = cfg_q.lane_code;

  // R9: chip select high whenever no frame runs
  a_r9_idle_csn_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> csn_q);

  // R8: completion is a single-cycle pulse
  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);

  // R8: serial clock rises only inside a frame
  a_r8_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> !csn_q);

  // R10: lines released whenever data is sampled
  a_r10_sample_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sample |-> (io_oe == 4'b0000));

  // R2: rejected load answers on the next edge with zero data
  a_r2_reject_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && bus_req && !ready_q && !engine_ok)
      |=> (ready_q && rdata_q == '0));

endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader #(
  parameter int ADDR_W    = 24,
  parameter int BUS_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   map_wr,
  input  logic                   map_wdata,
  input  logic [1:0]             ce_mode,
  input  logic                   cfg_with_cmd,
  input  logic                   cfg_addr4,
  input  logic                   cfg_cmd4,
  input  logic                   cfg_fast,
  input  logic [1:0]             cfg_lanes,
  input  logic [3:0]             cfg_dummy,
  input  logic [7:0]             cfg_opcode,
  input  logic                   reg_go,
  output logic                   reg_start,
  input  logic                   bus_req,
  input  logic [ADDR_W-1:0]      bus_addr,
  output logic                   bus_ready,
  output logic [8*BUS_BYTES-1:0] bus_rdata,
  output logic                   spi_sck,
  output logic                   spi_csn,
  output logic [3:0]             spi_io_out,
  output logic [3:0]             spi_io_oe,
  input  logic [3:0]             spi_io_in
);

  localparam int DW = 8 * BUS_BYTES;

  logic          map_en;
  logic          ce_hw;
  logic          engine_ok;
  logic          csn_hw;
  logic          io_out0;
  logic          rx_clear;
  logic          rx_sample;
  logic [1:0]    lane_code;
  logic [DW-1:0] rx_word;

  assign ce_hw     = (ce_mode == 2'b00);
  assign engine_ok = map_en & ce_hw;

  fwr_map_reg i_map_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_wr    (map_wr),
    .map_wdata (map_wdata),
    .reg_go    (reg_go),
    .map_en    (map_en),
    .reg_start (reg_start)
  );

  fwr_sequencer #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .engine_ok    (engine_ok),
    .cfg_with_cmd (cfg_with_cmd),
    .cfg_addr4    (cfg_addr4),
    .cfg_cmd4     (cfg_cmd4),
    .cfg_fast     (cfg_fast),
    .cfg_lanes    (cfg_lanes),
    .cfg_dummy    (cfg_dummy),
    .cfg_opcode   (cfg_opcode),
    .rx_word      (rx_word),
    .bus_ready    (bus_ready),
    .bus_rdata    (bus_rdata),
    .sck          (spi_sck),
    .csn_hw       (csn_hw),
    .io_out0      (io_out0),
    .io_oe        (spi_io_oe),
    .rx_clear     (rx_clear),
    .rx_sample    (rx_sample),
    .lane_code    (lane_code)
  );

  fwr_rx_gather #(
    .BUS_BYTES (BUS_BYTES)
  ) i_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rx_clear),
    .sample    (rx_sample),
    .lane_code (lane_code),
    .io_in     (spi_io_in),
    .word      (rx_word)
  );

  assign spi_csn    = ce_hw ? csn_hw : ce_mode[0];
  assign spi_io_out = {3'b000, io_out0};

endmodule

// File: tb/test_flash_window_reader.sv
module test_flash_window_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_wr = 1'b0, map_wdata = 1'b0;
  logic [1:0]  ce_mode = 2'b00;
  logic        cfg_with_cmd = 1'b1, cfg_addr4 = 1'b0, cfg_cmd4 = 1'b0, cfg_fast = 1'b0;
  logic [1:0]  cfg_lanes = 2'd0;
  logic [3:0]  cfg_dummy = 4'd0;
  logic [7:0]  cfg_opcode = 8'h03;
  logic        reg_go = 1'b0;
  logic        reg_start;
  logic        bus_req = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_csn;
  logic [3:0]  spi_io_out, spi_io_oe;
  logic [3:0]  spi_io_in = 4'b0000;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_window_reader i_flash_window_reader (
    .clk (clk), .rst_n (rst_n), .map_wr (map_wr), .map_wdata (map_wdata),
    .ce_mode (ce_mode), .cfg_with_cmd (cfg_with_cmd), .cfg_addr4 (cfg_addr4),
    .cfg_cmd4 (cfg_cmd4), .cfg_fast (cfg_fast), .cfg_lanes (cfg_lanes),
    .cfg_dummy (cfg_dummy), .cfg_opcode (cfg_opcode), .reg_go (reg_go),
    .reg_start (reg_start), .bus_req (bus_req), .bus_addr (bus_addr),
    .bus_ready (bus_ready), .bus_rdata (bus_rdata), .spi_sck (spi_sck),
    .spi_csn (spi_csn), .spi_io_out (spi_io_out), .spi_io_oe (spi_io_oe),
    .spi_io_in (spi_io_in)
  );

  // ---------------- behavioural flash model ----------------
  int          cur_addr = 0, cur_pre = 0, cur_dum = 0, cur_lanes = 1;
  int          rise_cnt = 0, oe_err = 0, sck_rises = 0;
  logic [63:0] cap = '0;
  int          g_idx, p_idx, l_idx;
  logic [3:0]  drv;

  function automatic logic [7:0] fbyte(input int a);
    logic [31:0] v;
    v = a;
    return (v[7:0] * 8'd13) ^ v[15:8] ^ 8'h5A;
  endfunction

  function automatic logic fbit(input int a, input int p);
    logic [7:0] b;
    b = fbyte(a + p / 8);
    return b[7 - (p % 8)];
  endfunction

  always @(negedge spi_csn) begin
    rise_cnt = 0;
    cap      = '0;
  end

  always @(posedge spi_sck) begin
    sck_rises++;
    if (rise_cnt < cur_pre) begin
      cap = {cap[62:0], spi_io_out[0]};
      if (spi_io_oe !== 4'b0001) oe_err++;
    end else if (spi_io_oe !== 4'b0000) begin
      oe_err++;
    end
    rise_cnt++;
  end

  always @(negedge spi_sck) begin
    if (rise_cnt >= cur_pre + cur_dum) begin
      g_idx = rise_cnt - cur_pre - cur_dum;
      drv   = 4'b0000;
      for (int j = 0; j < cur_lanes; j++) begin
        p_idx = g_idx * cur_lanes + j;
        l_idx = (cur_lanes == 1) ? 1 : (cur_lanes == 2) ? (1 - j) : (3 - j);
        drv[l_idx] = fbit(cur_addr, p_idx);
      end
      spi_io_in = drv;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic load(input int a, input bit cmd, input bit a4, input bit c4,
                      input bit fast, input logic [1:0] lanes, input int dum,
                      input logic [7:0] op, input bit active, input logic idle_csn,
                      input string tag);
    int          nb, lw, n, cyc, csn_bad, rises0;
    logic [63:0] exp_cap, mask;
    logic [31:0] exp_data, got;
    nb = (a4 || c4) ? 4 : 3;
    lw = (lanes == 2'd1) ? 2 : (lanes == 2'd2) ? 4 : 1;
    n  = (cmd ? 8 : 0) + 8 * nb + (fast ? dum : 0) + 32 / lw;
    @(negedge clk);
    cfg_with_cmd = cmd; cfg_addr4 = a4; cfg_cmd4 = c4; cfg_fast = fast;
    cfg_lanes = lanes; cfg_dummy = 4'(dum); cfg_opcode = op;
    cur_addr = a; cur_pre = (cmd ? 8 : 0) + 8 * nb; cur_dum = fast ? dum : 0;
    cur_lanes = lw; oe_err = 0; rises0 = sck_rises;
    bus_addr = 24'(a); bus_req = 1'b1;
    cyc = 0; csn_bad = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (!bus_ready && spi_csn !== (active ? 1'b0 : idle_csn)) csn_bad++;
    end while (!bus_ready && cyc < 2000);
    got = bus_rdata;
    bus_req = 1'b0;
    chk(csn_bad == 0, active ? "R3" : "R2", "csn level each cycle", csn_bad, 0);
    chk(spi_csn === idle_csn, "R9", "csn at completion", spi_csn, idle_csn);
    chk(cyc == (active ? 2 * n + 1 : 1), active ? "R8" : "R2", "latency", cyc,
        active ? 2 * n + 1 : 1);
    exp_data = '0;
    if (active)
      for (int k = 0; k < 4; k++) exp_data[8*k +: 8] = fbyte(a + k);
    chk(got === exp_data, active ? "R7" : "R2", {tag, " data"}, got, exp_data);
    @(negedge clk);
    chk(bus_ready === 1'b0, "R8", "ready one cycle", bus_ready, 0);
    if (active) begin
      exp_cap = cmd ? 64'(op) : 64'd0;
      for (int b = nb - 1; b >= 0; b--) exp_cap = (exp_cap << 8) | 64'((a >> (8 * b)) & 255);
      mask = (64'd1 << cur_pre) - 64'd1;
      chk((cap & mask) === exp_cap, cmd ? "R3" : "R5", {tag, " cmd/addr bits (R4)"},
          cap & mask, exp_cap);
      chk(oe_err == 0, "R10", "output enable per phase", oe_err, 0);
    end else begin
      chk(sck_rises == rises0, "R2", "no sck activity", sck_rises - rises0, 0);
    end
  endtask

  task automatic write_map(input logic v);
    @(negedge clk);
    map_wr = 1'b1; map_wdata = v;
    @(negedge clk);
    map_wr = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_csn === 1'b1, "R9", "reset csn", spi_csn, 1);
    chk(spi_sck === 1'b0, "R9", "reset sck", spi_sck, 0);
    chk(bus_ready === 1'b0, "R8", "reset ready", bus_ready, 0);
    chk(spi_io_oe === 4'b0000, "R10", "reset oe", spi_io_oe, 0);

    // R1: enabled after reset, plain 3-byte single-lane read
    load(24'h12_34_56, 1, 0, 0, 0, 2'd0, 0, 8'h03, 1, 1'b1, "R1 default");
    // R4: 4-byte address via address flag, R6 fast with 8 dummies
    load(24'hAB_CD_EF, 1, 1, 0, 1, 2'd0, 8, 8'h0C, 1, 1'b1, "R4 addr4");
    // R4: 4-byte command flag alone
    load(24'h00_10_20, 1, 0, 1, 0, 2'd0, 0, 8'h13, 1, 1'b1, "R4 cmd4");
    // R7: two lanes
    load(24'h05_55_AA, 1, 0, 0, 1, 2'd1, 8, 8'h3B, 1, 1'b1, "R7 x2");
    // R7: four lanes
    load(24'h7F_00_81, 1, 1, 0, 1, 2'd2, 6, 8'h6C, 1, 1'b1, "R7 x4");
    // R7: code 3 acts as one lane
    load(24'h00_00_FF, 1, 0, 0, 0, 2'd3, 0, 8'h03, 1, 1'b1, "R7 code3");
    // R6: dummy count ignored without fast mode
    load(24'h31_41_59, 1, 0, 0, 0, 2'd0, 10, 8'h03, 1, 1'b1, "R6 nofast");
    // R5: no command phase, maximum dummy
    load(24'h26_53_58, 0, 0, 0, 1, 2'd2, 15, 8'hFF, 1, 1'b1, "R5 nocmd");
    // R6: fast with zero dummy
    load(24'h97_93_23, 1, 0, 0, 1, 2'd1, 0, 8'h0B, 1, 1'b1, "R6 dummy0");

    // R11: go blocked while map enabled
    @(negedge clk); reg_go = 1'b1;
    #1 chk(reg_start === 1'b0, "R11", "go blocked", reg_start, 0);
    @(negedge clk); reg_go = 1'b0;

    // R1/R2: disable the map
    write_map(1'b0);
    load(24'h11_22_33, 1, 0, 0, 0, 2'd0, 0, 8'h03, 0, 1'b1, "R1 disabled");
    @(negedge clk); reg_go = 1'b1;
    #1 chk(reg_start === 1'b1, "R11", "go passes", reg_start, 1);
    @(negedge clk); reg_go = 1'b0;

    // R1: re-enable, R2/R9: manual chip-enable mode
    write_map(1'b1);
    @(negedge clk); ce_mode = 2'b11;
    load(24'h44_55_66, 1, 0, 0, 0, 2'd0, 0, 8'h03, 0, 1'b1, "R2 manual");
    @(negedge clk); ce_mode = 2'b10;
    #1 chk(spi_csn === 1'b0, "R9", "manual csn low", spi_csn, 0);
    @(negedge clk); ce_mode = 2'b00;
    #1 chk(spi_csn === 1'b1, "R9", "hardware idle csn", spi_csn, 1);
    load(24'h0A_0B_0C, 1, 1, 1, 1, 2'd2, 4, 8'hEC, 1, 1'b1, "R1 reenabled");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule